// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings a display panel out of power-on reset and moves it into and out of standby. It drives the panel's active-low hardware reset line. It also feeds a fixed series of command and parameter bytes, one at a time, to an external serial command writer. Every byte comes from a small internal step table. Each step carries a command/parameter flag, the byte itself and a 3-bit code for the pause that follows it. The block hands each step over and waits for the writer to report completion. It then counts out the pause in 1 ms units, taken from a parameterised clock prescaler.

There are three procedures, each with its own entry point into the step table: power-up, standby entry and standby exit. A compile-time option adds a deep-standby variant. In that variant, standby entry writes two extra register pairs, and standby exit starts with a fresh hardware reset pulse. `busy` covers a whole procedure. `ready` reports that the power-up procedure has completed.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `busy`, `ready`, `ser_req` and `panel_rst_n` are all 0.
- R2: An accepted power-up request drives `panel_rst_n` low for exactly `RST_LO_MS` ms (default 2), counted from the first cycle `busy` is high. It then releases it, and the first `ser_req` appears exactly `RST_WAIT_MS` ms (default 6) later; one ms is `CLK_PER_MS` clock cycles.
- R3: `ser_req` stays high with a stable `ser_byte` and `ser_dc` until `ser_done` is seen. The next step, or its pause, starts in the cycle after `ser_done`.
- R4: Power-up sends, in order (C = command with `ser_dc`=0, D = parameter with `ser_dc`=1, pause after the step in ms): C 01h 10; C 11h 200; C B0h; D 04h; C B0h; D 03h 50; C 36h; D 00h 20; C 3Ah; D 77h 20; C 29h.
- R5: The pause after a step lasts exactly its ms value times `CLK_PER_MS` cycles, counted from the cycle after `ser_done`. The codes 0..7 map to 0, 1, 2, 10, 20, 50, 100 and 200 ms.
- R6: With `DEEP_STBY`=0, standby entry sends C 28h, then C 10h followed by 100 ms. It uses no reset pulse.
- R7: With `DEEP_STBY`=1, standby entry continues with C B0h; D 04h; C B1h; D 01h followed by 1 ms. Standby exit begins with the same reset pulse and wait as R2.
- R8: Standby exit sends C 11h 100; C 36h; D 00h 20; C 3Ah; D 77h 20; C 29h.
- R9: `ready` clears when a power-up request is accepted and sets when the power-up procedure ends. Standby procedures leave it unchanged.
- R10: Requests are accepted only while `busy` is 0. A request seen while busy is dropped, not queued. Standby requests are ignored while `ready` is 0.
- R11: When several requests arrive in the same idle cycle, power-up wins over standby entry, and standby entry wins over standby exit.
- R12: `busy` rises in the cycle after an accepted request and falls when the last step's pause ends. A procedure with no reset pulse raises `ser_req` in that same first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_init | input | 1 | Request the power-up procedure |
| start_sleep_in | input | 1 | Request standby entry |
| start_sleep_out | input | 1 | Request standby exit |
| busy | output | 1 | A procedure is running |
| ready | output | 1 | Power-up procedure has completed |
| panel_rst_n | output | 1 | Active-low hardware reset to the panel |
| ser_req | output | 1 | Step available to the serial writer |
| ser_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| ser_byte | output | 8 | Byte to send |
| ser_done | input | 1 | One-cycle pulse: serial writer finished the step |

## Verification
A wrong step pointer shows up at the next `ser_req` as an out-of-order byte or a flipped `ser_dc`, within one serial transfer of the fault. A wrong pause counter or prescaler phase shifts the next `ser_req` (or the fall of `busy`) by whole cycles. The bench measures this exactly against the listed milliseconds, so a one-cycle slip is caught at the end of the affected pause. A wrong `ready` or procedure register shows up at the end of the procedure, or as a standby request that starts or is dropped wrongly on the next idle cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [2:0] {
      DLY_NONE  = 3'd0,
      DLY_1MS   = 3'd1,
      DLY_2MS   = 3'd2,
      DLY_10MS  = 3'd3,
      DLY_20MS  = 3'd4,
      DLY_50MS  = 3'd5,
      DLY_100MS = 3'd6,
      DLY_200MS = 3'd7
   } dly_code_e;

   typedef struct packed {
      logic       last;
      logic       is_data;
      logic [7:0] val;
      dly_code_e  dly;
   } step_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_LO,
      ST_RST_WAIT,
      ST_SEND,
      ST_DELAY
   } seq_st_e;

   typedef enum logic [1:0] {
      PR_INIT,
      PR_SLEEP_IN,
      PR_SLEEP_OUT
   } proc_e;

   localparam int INIT_BASE  = 0;
   localparam int INIT_LEN   = 11;
   localparam int SLPIN_BASE = INIT_BASE + INIT_LEN;
   localparam int SLPOUT_LEN = 6;
   localparam int MAX_DLY_MS = 200;

   function automatic int slpin_len(input int deep);
      return (deep != 0) ? 6 : 2;
   endfunction

   function automatic logic [7:0] dly_ms(input dly_code_e c);
      case (c)
         DLY_1MS:   return 8'd1;
         DLY_2MS:   return 8'd2;
         DLY_10MS:  return 8'd10;
         DLY_20MS:  return 8'd20;
         DLY_50MS:  return 8'd50;
         DLY_100MS: return 8'd100;
         DLY_200MS: return 8'd200;
         default:   return 8'd0;
      endcase
   endfunction

   function automatic step_t mk_step(input logic l, input logic d,
                                     input logic [7:0] v, input dly_code_e c);
      step_t s;
      s.last    = l;
      s.is_data = d;
      s.val     = v;
      s.dly     = c;
      return s;
   endfunction

endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
   parameter int CLK_PER_MS = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;

   if (CLK_PER_MS < 2) begin : g_bad_div
      $error("pps_tick: CLK_PER_MS must be at least 2");
   end

   logic [CW-1:0] pcnt;

   assign tick = (pcnt == CW'(CLK_PER_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pcnt <= '0;
      else if (clr)    pcnt <= '0;
      else if (tick)   pcnt <= '0;
      else             pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/pps_rom.sv
module pps_rom
   import pps_pkg::*;
#(
   parameter int DEEP_STBY = 0,
   parameter int AW        = 5
) (
   input  logic [AW-1:0] addr,
   output step_t         step
);
   localparam int SI_LEN  = slpin_len(DEEP_STBY);
   localparam int SO_BASE = SLPIN_BASE + SI_LEN;
   localparam int DEPTH   = SO_BASE + SLPOUT_LEN;

   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("pps_rom: AW too small for the step table");
   end

   logic [AW-1:0] rel_si, rel_so;
   step_t         init_s, si_s, so_s;

   assign rel_si = addr - AW'(SLPIN_BASE);
   assign rel_so = addr - AW'(SO_BASE);

   // power-up list
   always_comb begin
      case (32'(addr))
         0:       init_s = mk_step(1'b0, 1'b0, 8'h01, DLY_10MS);
         1:       init_s = mk_step(1'b0, 1'b0, 8'h11, DLY_200MS);
         2:       init_s = mk_step(1'b0, 1'b0, 8'hB0, DLY_NONE);
         3:       init_s = mk_step(1'b0, 1'b1, 8'h04, DLY_NONE);
         4:       init_s = mk_step(1'b0, 1'b0, 8'hB0, DLY_NONE);
         5:       init_s = mk_step(1'b0, 1'b1, 8'h03, DLY_50MS);
         6:       init_s = mk_step(1'b0, 1'b0, 8'h36, DLY_NONE);
         7:       init_s = mk_step(1'b0, 1'b1, 8'h00, DLY_20MS);
         8:       init_s = mk_step(1'b0, 1'b0, 8'h3A, DLY_NONE);
         9:       init_s = mk_step(1'b0, 1'b1, 8'h77, DLY_20MS);
         default: init_s = mk_step(1'b1, 1'b0, 8'h29, DLY_NONE);
      endcase
   end

   // standby-entry list: variant chosen by the deep-standby option
   if (DEEP_STBY != 0) begin : g_deep
      always_comb begin
         case (32'(rel_si))
            0:       si_s = mk_step(1'b0, 1'b0, 8'h28, DLY_NONE);
            1:       si_s = mk_step(1'b0, 1'b0, 8'h10, DLY_100MS);
            2:       si_s = mk_step(1'b0, 1'b0, 8'hB0, DLY_NONE);
            3:       si_s = mk_step(1'b0, 1'b1, 8'h04, DLY_NONE);
            4:       si_s = mk_step(1'b0, 1'b0, 8'hB1, DLY_NONE);
            default: si_s = mk_step(1'b1, 1'b1, 8'h01, DLY_1MS);
         endcase
      end
   end else begin : g_plain
      always_comb begin
         case (32'(rel_si))
            0:       si_s = mk_step(1'b0, 1'b0, 8'h28, DLY_NONE);
            default: si_s = mk_step(1'b1, 1'b0, 8'h10, DLY_100MS);
         endcase
      end
   end

   // standby-exit list
   always_comb begin
      case (32'(rel_so))
         0:       so_s = mk_step(1'b0, 1'b0, 8'h11, DLY_100MS);
         1:       so_s = mk_step(1'b0, 1'b0, 8'h36, DLY_NONE);
         2:       so_s = mk_step(1'b0, 1'b1, 8'h00, DLY_20MS);
         3:       so_s = mk_step(1'b0, 1'b0, 8'h3A, DLY_NONE);
         4:       so_s = mk_step(1'b0, 1'b1, 8'h77, DLY_20MS);
         default: so_s = mk_step(1'b1, 1'b0, 8'h29, DLY_NONE);
      endcase
   end

   always_comb begin
      if (addr < AW'(SLPIN_BASE))   step = init_s;
      else if (addr < AW'(SO_BASE)) step = si_s;
      else                          step = so_s;
   end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import pps_pkg::*;
#(
   parameter int CLK_PER_MS  = 125000,
   parameter int DEEP_STBY   = 0,
   parameter int RST_LO_MS   = 2,
   parameter int RST_WAIT_MS = 6,
   parameter int MS_W        = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_init,
   input  logic       start_sleep_in,
   input  logic       start_sleep_out,
   output logic       busy,
   output logic       ready,
   output logic       panel_rst_n,
   output logic       ser_req,
   output logic       ser_dc,
   output logic [7:0] ser_byte,
   input  logic       ser_done
);
   localparam int SO_BASE  = SLPIN_BASE + slpin_len(DEEP_STBY);
   localparam int DEPTH    = SO_BASE + SLPOUT_LEN;
   localparam int AW       = $clog2(DEPTH);
   localparam bit HAS_DEEP = (DEEP_STBY != 0);

   if (DEEP_STBY != 0 && DEEP_STBY != 1) begin : g_bad_deep
      $error("panel_pwr_seq: DEEP_STBY must be 0 or 1");
   end
   if (RST_LO_MS < 1 || RST_WAIT_MS < 1) begin : g_bad_rst
      $error("panel_pwr_seq: reset phases need at least 1 ms");
   end
   if (RST_LO_MS >= (1 << MS_W) || RST_WAIT_MS >= (1 << MS_W) ||
       MAX_DLY_MS >= (1 << MS_W)) begin : g_bad_msw
      $error("panel_pwr_seq: MS_W too narrow for the longest wait");
   end

   seq_st_e          st, st_nxt;
   proc_e            proc_q;
   logic [AW-1:0]    addr, addr_nxt;
   logic [MS_W-1:0]  ms_left, ms_nxt;
   step_t            step;
   logic             tick, tk_clr;
   logic             go_init, go_si, go_so, ms_end, finishing;
   logic [MS_W-1:0]  step_ms;

   pps_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tk_clr),
      .tick (tick)
   );

   pps_rom #(.DEEP_STBY(DEEP_STBY), .AW(AW)) u_rom (
      .addr(addr),
      .step(step)
   );

   assign go_init = (st == ST_IDLE) && start_init;
   assign go_si   = (st == ST_IDLE) && !start_init && ready && start_sleep_in;
   assign go_so   = (st == ST_IDLE) && !start_init && !start_sleep_in &&
                    ready && start_sleep_out;
   assign ms_end  = tick && (ms_left == MS_W'(1));
   assign step_ms = MS_W'(dly_ms(step.dly));

   always_comb begin
      st_nxt   = st;
      addr_nxt = addr;
      ms_nxt   = ms_left;
      case (st)
         ST_IDLE: begin
            if (go_init) begin
               st_nxt   = ST_RST_LO;
               addr_nxt = AW'(INIT_BASE);
               ms_nxt   = MS_W'(RST_LO_MS);
            end else if (go_si) begin
               st_nxt   = ST_SEND;
               addr_nxt = AW'(SLPIN_BASE);
            end else if (go_so) begin
               addr_nxt = AW'(SO_BASE);
               if (HAS_DEEP) begin
                  st_nxt = ST_RST_LO;
                  ms_nxt = MS_W'(RST_LO_MS);
               end else begin
                  st_nxt = ST_SEND;
               end
            end
         end
         ST_RST_LO: begin
            if (ms_end) begin
               st_nxt = ST_RST_WAIT;
               ms_nxt = MS_W'(RST_WAIT_MS);
            end else if (tick) begin
               ms_nxt = ms_left - 1'b1;
            end
         end
         ST_RST_WAIT: begin
            if (ms_end)      st_nxt = ST_SEND;
            else if (tick)   ms_nxt = ms_left - 1'b1;
         end
         ST_SEND: begin
            if (ser_done) begin
               if (step_ms != '0) begin
                  st_nxt = ST_DELAY;
                  ms_nxt = step_ms;
               end else if (step.last) begin
                  st_nxt = ST_IDLE;
               end else begin
                  addr_nxt = addr + 1'b1;
               end
            end
         end
         ST_DELAY: begin
            if (ms_end) begin
               if (step.last) begin
                  st_nxt = ST_IDLE;
               end else begin
                  st_nxt   = ST_SEND;
                  addr_nxt = addr + 1'b1;
               end
            end else if (tick) begin
               ms_nxt = ms_left - 1'b1;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   // every state change restarts the ms prescaler, so each wait is exact
   assign tk_clr    = (st_nxt != st);
   assign finishing = (st != ST_IDLE) && (st_nxt == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr    <= '0;
         ms_left <= '0;
      end else begin
         st      <= st_nxt;
         addr    <= addr_nxt;
         ms_left <= ms_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       proc_q <= PR_INIT;
      else if (go_init) proc_q <= PR_INIT;
      else if (go_si)   proc_q <= PR_SLEEP_IN;
      else if (go_so)   proc_q <= PR_SLEEP_OUT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ready <= 1'b0;
      else if (go_init)                             ready <= 1'b0;
      else if (finishing && proc_q == PR_INIT)      ready <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         panel_rst_n <= 1'b0;
      else if (st_nxt == ST_RST_LO && st != ST_RST_LO)
         panel_rst_n <= 1'b0;
      else if (st == ST_RST_LO && st_nxt == ST_RST_WAIT)
         panel_rst_n <= 1'b1;
   end

   assign busy     = (st != ST_IDLE);
   assign ser_req  = (st == ST_SEND);
   assign ser_dc   = ser_req & step.is_data;
   assign ser_byte = ser_req ? step.val : 8'h00;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_init,
   input logic       start_sleep_in,
   input logic       start_sleep_out,
   input logic       ser_done,
   input logic       busy,
   input logic       ready,
   input logic       panel_rst_n,
   input logic       ser_req,
   input logic       ser_dc,
   input logic [7:0] ser_byte
);
   a_r12_req_in_proc: assert property (@(posedge clk) disable iff (!rst_n)
      ser_req |-> busy);

   a_r3_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_req && !ser_done) |=> (ser_req && $stable(ser_byte) && $stable(ser_dc)));

   a_r10_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_init || (ready && (start_sleep_in || start_sleep_out))));

   a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(start_init && !busy));

   a_r2_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_rst_n) |-> (busy && !ser_req));
endmodule

bind panel_pwr_seq pps_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_init     (start_init),
   .start_sleep_in (start_sleep_in),
   .start_sleep_out(start_sleep_out),
   .ser_done       (ser_done),
   .busy           (busy),
   .ready          (ready),
   .panel_rst_n    (panel_rst_n),
   .ser_req        (ser_req),
   .ser_dc         (ser_dc),
   .ser_byte       (ser_byte)
);

// File: tb/panel_pwr_seq_bench.sv
`timescale 1ns/1ps
module panel_pwr_seq_bench;
   localparam int CPM = 4;
   localparam int RLO = 2;
   localparam int RWT = 6;
   localparam int GUARD = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_init = 1'b0, st_si = 1'b0, st_so = 1'b0;
   logic [1:0] busy, ready, prst, req, dc;
   logic [7:0] byt [2];
   logic       done [2];
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // index 0: plain standby, index 1: deep standby
   panel_pwr_seq #(.CLK_PER_MS(CPM), .DEEP_STBY(0)) u_panel_pwr_seq (
      .clk(clk), .rst_n(rst_n), .start_init(st_init), .start_sleep_in(st_si),
      .start_sleep_out(st_so), .busy(busy[0]), .ready(ready[0]), .panel_rst_n(prst[0]),
      .ser_req(req[0]), .ser_dc(dc[0]), .ser_byte(byt[0]), .ser_done(done[0]));

   panel_pwr_seq #(.CLK_PER_MS(CPM), .DEEP_STBY(1)) u_panel_pwr_seq_deep (
      .clk(clk), .rst_n(rst_n), .start_init(st_init), .start_sleep_in(st_si),
      .start_sleep_out(st_so), .busy(busy[1]), .ready(ready[1]), .panel_rst_n(prst[1]),
      .ser_req(req[1]), .ser_dc(dc[1]), .ser_byte(byt[1]), .ser_done(done[1]));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // expected lists: p 0 power-up, 1 standby entry, 2 standby exit; d deep option
   function automatic int exp_len(input int p, input int d);
      if (p == 0) return 11;
      if (p == 1) return (d != 0) ? 6 : 2;
      return 6;
   endfunction

   function automatic bit has_pulse(input int p, input int d);
      return (p == 0) || (p == 2 && d != 0);
   endfunction

   // {dc, byte, pause in ms}
   function automatic logic [16:0] exp_ent(input int p, input int i);
      if (p == 0) begin
         case (i)
            0: return {1'b0, 8'h01, 8'd10};
            1: return {1'b0, 8'h11, 8'd200};
            2: return {1'b0, 8'hB0, 8'd0};
            3: return {1'b1, 8'h04, 8'd0};
            4: return {1'b0, 8'hB0, 8'd0};
            5: return {1'b1, 8'h03, 8'd50};
            6: return {1'b0, 8'h36, 8'd0};
            7: return {1'b1, 8'h00, 8'd20};
            8: return {1'b0, 8'h3A, 8'd0};
            9: return {1'b1, 8'h77, 8'd20};
            default: return {1'b0, 8'h29, 8'd0};
         endcase
      end else if (p == 1) begin
         case (i)
            0: return {1'b0, 8'h28, 8'd0};
            1: return {1'b0, 8'h10, 8'd100};
            2: return {1'b0, 8'hB0, 8'd0};
            3: return {1'b1, 8'h04, 8'd0};
            4: return {1'b0, 8'hB1, 8'd0};
            default: return {1'b1, 8'h01, 8'd1};
         endcase
      end else begin
         case (i)
            0: return {1'b0, 8'h11, 8'd100};
            1: return {1'b0, 8'h36, 8'd0};
            2: return {1'b1, 8'h00, 8'd20};
            3: return {1'b0, 8'h3A, 8'd0};
            4: return {1'b1, 8'h77, 8'd20};
            default: return {1'b0, 8'h29, 8'd0};
         endcase
      end
   endfunction

   // serial-writer model and checker for one instance; starts in first busy cycle
   task automatic run_proc(input int v, input int p, input string pre);
      int g;
      int n;
      logic [16:0] e;
      string tg;
      tg = (p == 0) ? "R4" : (p == 1) ? ((v == 1) ? "R7" : "R6") : "R8";
      tg = {pre, tg};
      if (has_pulse(p, v)) begin
         g = 0;
         while (!prst[v] && g < GUARD) begin g++; @(negedge clk); end
         check(g == RLO * CPM, (p == 0) ? "R2 reset low time" : "R7 reset low time",
               g, RLO * CPM);
         g = 0;
         while (!req[v] && g < GUARD) begin g++; @(negedge clk); end
         check(g == RWT * CPM, (p == 0) ? "R2 wait after release" : "R7 wait after release",
               g, RWT * CPM);
      end else begin
         check(req[v] == 1'b1 && busy[v] == 1'b1, "R12 request in first busy cycle",
               {busy[v], req[v]}, 3);
      end
      n = exp_len(p, v);
      for (int i = 0; i < n; i++) begin
         e = exp_ent(p, i);
         check(req[v] && byt[v] == e[15:8] && dc[v] == e[16], tg,
               {req[v], dc[v], byt[v]}, {1'b1, e[16:8]});
         repeat ($urandom_range(0, 3)) @(negedge clk);
         check(req[v] && byt[v] == e[15:8], "R3 request held", {req[v], byt[v]},
               {1'b1, e[15:8]});
         done[v] = 1'b1;
         @(negedge clk);
         done[v] = 1'b0;
         g = 0;
         while (busy[v] && !req[v] && g < GUARD) begin g++; @(negedge clk); end
         check(g == int'(e[7:0]) * CPM, "R5 pause length", g, int'(e[7:0]) * CPM);
         if (i == n - 1)
            check(busy[v] == 1'b0, "R12 busy ends after last pause", busy[v], 0);
         else
            check(req[v] == 1'b1, "R3 next step follows", req[v], 1);
      end
      check(ready[v] == 1'b1, "R9 ready after procedure", ready[v], 1);
   endtask

   task automatic launch(input bit a, input bit b, input bit c, input int p,
                         input bit noise, input string pre);
      @(negedge clk);
      st_init = a; st_si = b; st_so = c;
      @(negedge clk);
      st_init = 1'b0; st_si = 1'b0; st_so = 1'b0;
      fork
         run_proc(0, p, pre);
         run_proc(1, p, pre);
         if (noise) begin
            repeat (20) @(negedge clk);
            st_init = 1'b1; st_si = 1'b1; st_so = 1'b1;
            @(negedge clk);
            st_init = 1'b0; st_si = 1'b0; st_so = 1'b0;
         end
      join
      repeat (3) @(negedge clk);
      check(busy == 2'b00, "R10 no queued request", busy, 0);
   endtask

   initial begin
      done[0] = 1'b0;
      done[1] = 1'b0;
      void'($urandom(32'd917));
      repeat (5) @(negedge clk);
      check(busy == 2'b00 && ready == 2'b00, "R1 busy/ready in reset", {busy, ready}, 0);
      check(prst == 2'b00 && req == 2'b00, "R1 reset/req in reset", {prst, req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 2'b00 && ready == 2'b00 && prst == 2'b00 && req == 2'b00,
            "R1 idle after release", {busy, ready, prst, req}, 0);
      // standby requests before power-up are ignored
      @(negedge clk);
      st_si = 1'b1; st_so = 1'b1;
      @(negedge clk);
      st_si = 1'b0; st_so = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 2'b00 && req == 2'b00, "R10 standby ignored before ready",
            {busy, req}, 0);

      launch(1'b1, 1'b0, 1'b0, 0, 1'b0, "");
      launch(1'b0, 1'b1, 1'b0, 1, 1'b0, "");
      launch(1'b0, 1'b0, 1'b1, 2, 1'b0, "");
      // R11 priority, with requests injected while busy (R10)
      launch(1'b1, 1'b1, 1'b1, 0, 1'b1, "R11/");
      launch(1'b0, 1'b1, 1'b1, 1, 1'b1, "R11/");
      launch(1'b0, 1'b0, 1'b1, 2, 1'b1, "R10/");
      for (int k = 0; k < 6; k++) begin
         int r;
         r = int'($urandom_range(0, 2));
         launch(r == 0, r == 1, r == 2, r, 1'($urandom_range(0, 1)), "");
      end
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
   end
endmodule